// File: doc/BRIEF.md
# Stop-State Pin Wake Detector

This block decides when a device parked in its low-power stop state should be woken by its input pins. A small configuration register holds a 3-bit source selector and a polarity bit. The selector picks one of several NAND or NOR combinations of pins from three 8-bit input ports. The polarity bit says whether the wake condition is that combination being low or being high.

All pin inputs pass through a synchronizer before they are combined. The wake request is a register, so a glitch on the combining logic cannot produce a wake. The request is raised only while `stop_active_i` is high. Once raised, it stays high until `stop_active_i` falls.

Source value 0 turns pin wake off entirely, so only a reset can end the stop state. Restarting clocks and waiting for the oscillator to settle are left to other logic.

Top module: `stop_wake_detect`

## Requirements
- R1: After reset, `cfg_rdata_o` reads 0x00 and `wake_o` is 0.
- R2: On a write, the source selector is taken from `cfg_wdata_i[4:2]` and the polarity bit from `cfg_wdata_i[6]`. The new value is readable on the cycle after the write. Bits 7, 5, 1 and 0 always read 0 and ignore written data.
- R3: With source 0, `wake_o` never rises, whatever the pins and the polarity.
- R4: Source 1 uses the NAND of port 2 bits 3..0. Source 2 uses the NAND of port 2 bits 7..0.
- R5: Source 3 uses the NOR of port 3 bits 3..1. Source 4 uses the NAND of port 3 bits 3..1.
- R6: Source 5 uses the NOR of port 3 bits 3..1 together with port 0 bits 0 and 7. Source 6 uses the NAND of that same set of bits.
- R7: Source 7 uses the NAND of port 3 bits 3..1 together with port 2 bits 2..0.
- R8: With polarity 0, the wake condition is that the selected combination is 0. With polarity 1, the wake condition is that it is 1.
- R9: `wake_o` can rise only while `stop_active_i` is high. Once high, it stays high for as long as `stop_active_i` stays high. It is 0 on the cycle after `stop_active_i` is seen low.
- R10: A pin change reaches `wake_o` on the third rising clock edge after the change. This delay covers two synchronizer stages plus the wake register. A configuration write affects `wake_o` from the edge after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Configuration readback |
| stop_active_i | input | 1 | High while the device is in the stop state |
| port0_i | input | 8 | Port 0 pins (asynchronous) |
| port2_i | input | 8 | Port 2 pins (asynchronous) |
| port3_i | input | 8 | Port 3 pins (asynchronous) |
| wake_o | output | 1 | Registered, held wake request |

## Verification
Each source is driven with all pins high and then all pins low. Because every selectable term is a NAND or a NOR, this flips the selected combination for every source, and doing it under both polarities separates the two polarity settings.

Single-pin moves inside and just outside each source's pin group show that a source ignores pins it does not select. An exact count of edges after a pin change pins down the synchronizer depth. A long random run toggles stop-active, the configuration and the pins, and compares the outputs on every clock against a queue-based model. This exposes wrong pin groups, NAND/NOR swaps, and loss of the hold-until-exit behaviour.

// File: rtl/swd_pkg.sv
package swd_pkg;
  localparam int unsigned PORT_W = 8;
  localparam int unsigned SRC_W  = 3;

  typedef enum logic [SRC_W-1:0] {
    SRC_RESET_ONLY = 3'd0,
    SRC_NAND_P2LO  = 3'd1,
    SRC_NAND_P2    = 3'd2,
    SRC_NOR_P3     = 3'd3,
    SRC_NAND_P3    = 3'd4,
    SRC_NOR_P3P0   = 3'd5,
    SRC_NAND_P3P0  = 3'd6,
    SRC_NAND_P3P2  = 3'd7
  } wake_src_e;

  typedef struct packed {
    logic      level;
    wake_src_e src;
  } wake_cfg_t;
endpackage

// File: rtl/swd_sync.sv
module swd_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg[i] <= '0;
      else if (i == 0) stg[i] <= d_i;
      else             stg[i] <= stg[(i == 0) ? 0 : i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/swd_cfg_reg.sv
module swd_cfg_reg
  import swd_pkg::*;
#(
  parameter int unsigned SRC_LSB = 2,
  parameter int unsigned LVL_BIT = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output wake_cfg_t  cfg_o
);
  wake_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '{level: 1'b0, src: SRC_RESET_ONLY};
    end else if (we_i) begin
      cfg_q.level <= wdata_i[LVL_BIT];
      cfg_q.src   <= wake_src_e'(wdata_i[SRC_LSB +: SRC_W]);
    end
  end

  always_comb begin
    rdata_o = '0;
    rdata_o[LVL_BIT]            = cfg_q.level;
    rdata_o[SRC_LSB +: SRC_W]   = cfg_q.src;
  end

  assign cfg_o = cfg_q;

  assert_cfg_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (rdata_o == {1'b0, $past(wdata_i[6]), 1'b0, $past(wdata_i[4:2]), 2'b00}));
endmodule

// File: rtl/swd_cond_sel.sv
module swd_cond_sel
  import swd_pkg::*;
(
  input  wake_src_e         src_i,
  input  logic [PORT_W-1:0] p0_i,
  input  logic [PORT_W-1:0] p2_i,
  input  logic [PORT_W-1:0] p3_i,
  output logic              en_o,
  output logic              comb_o
);
  logic [4:0] grp_p3p0;
  logic [5:0] grp_p3p2;

  assign grp_p3p0 = {p3_i[3:1], p0_i[0], p0_i[7]};
  assign grp_p3p2 = {p3_i[3:1], p2_i[2:0]};

  always_comb begin
    en_o   = 1'b1;
    comb_o = 1'b0;
    unique case (src_i)
      SRC_RESET_ONLY: en_o   = 1'b0;
      SRC_NAND_P2LO:  comb_o = ~&p2_i[3:0];
      SRC_NAND_P2:    comb_o = ~&p2_i;
      SRC_NOR_P3:     comb_o = ~|p3_i[3:1];
      SRC_NAND_P3:    comb_o = ~&p3_i[3:1];
      SRC_NOR_P3P0:   comb_o = ~|grp_p3p0;
      SRC_NAND_P3P0:  comb_o = ~&grp_p3p0;
      SRC_NAND_P3P2:  comb_o = ~&grp_p3p2;
      default:        en_o   = 1'b0;
    endcase
  end
endmodule

// File: rtl/stop_wake_detect.sv
module stop_wake_detect
  import swd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [7:0]        cfg_wdata_i,
  output logic [7:0]        cfg_rdata_o,
  input  logic              stop_active_i,
  input  logic [PORT_W-1:0] port0_i,
  input  logic [PORT_W-1:0] port2_i,
  input  logic [PORT_W-1:0] port3_i,
  output logic              wake_o
);
  localparam int unsigned SYNC_W = 3 * PORT_W;

  wake_cfg_t         cfg;
  logic [SYNC_W-1:0] pins_s;
  logic              sel_en, sel_comb, hit;
  logic              wake_q;

  swd_cfg_reg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .cfg_o   (cfg)
  );

  swd_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({port3_i, port2_i, port0_i}),
    .q_o    (pins_s)
  );

  swd_cond_sel u_sel (
    .src_i  (cfg.src),
    .p0_i   (pins_s[0 +: PORT_W]),
    .p2_i   (pins_s[PORT_W +: PORT_W]),
    .p3_i   (pins_s[2*PORT_W +: PORT_W]),
    .en_o   (sel_en),
    .comb_o (sel_comb)
  );

  // level 0: wake when combination low; level 1: when high
  assign hit = sel_en && (sel_comb == cfg.level);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             wake_q <= 1'b0;
    else if (!stop_active_i) wake_q <= 1'b0;
    else if (hit)            wake_q <= 1'b1;
  end

  assign wake_o = wake_q;

  assert_idle_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stop_active_i |=> !wake_o);
  assert_wake_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_o && stop_active_i) |=> wake_o);
  assert_rise_in_stop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_o) |-> $past(stop_active_i));
  assert_src0_no_wake_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rdata_o[4:2] == 3'd0 && !wake_o) |=> !wake_o);
endmodule

// File: tb/tb_stop_wake_detect.sv
module tb_stop_wake_detect;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [7:0] cfg_wdata_i = '0;
  logic [7:0] cfg_rdata_o;
  logic       stop_active_i = 1'b0;
  logic [7:0] port0_i = '0, port2_i = '0, port3_i = '0;
  logic       wake_o;

  int total = 0, bad = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  stop_wake_detect dut (.*);

  // reference model
  logic [23:0] hist[$];
  int  m_src = 0, m_lvl = 0;
  bit  m_wake = 0;

  function automatic bit comb_of(int s, logic [23:0] v);
    logic [7:0] p0, p2, p3;
    p0 = v[7:0]; p2 = v[15:8]; p3 = v[23:16];
    case (s)
      1: return !(p2[0] & p2[1] & p2[2] & p2[3]);
      2: return p2 != 8'hFF;
      3: return !(p3[1] | p3[2] | p3[3]);
      4: return !(p3[1] & p3[2] & p3[3]);
      5: return !(p3[1] | p3[2] | p3[3] | p0[0] | p0[7]);
      6: return !(p3[1] & p3[2] & p3[3] & p0[0] & p0[7]);
      7: return !(p3[1] & p3[2] & p3[3] & p2[0] & p2[1] & p2[2]);
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int s);
    case (s)
      0: return "R3";
      1, 2: return "R4";
      3, 4: return "R5";
      5, 6: return "R6";
      7: return "R7";
      default: return "R8";
    endcase
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist = {24'h0, 24'h0};
      m_src = 0; m_lvl = 0; m_wake = 0;
    end else begin
      bit nxt;
      logic [23:0] old;
      old = hist[0];
      if (!stop_active_i) nxt = 0;
      else if (m_wake) nxt = 1;
      else nxt = (m_src != 0) && (int'(comb_of(m_src, old)) == m_lvl);
      m_wake = nxt;
      hist.push_back({port3_i, port2_i, port0_i});
      void'(hist.pop_front());
      if (cfg_we_i) begin
        m_src = int'(cfg_wdata_i[4:2]);
        m_lvl = int'(cfg_wdata_i[6]);
      end
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison on negedge
  always @(negedge clk_i) if (rst_ni && !done) begin
    cycles++;
    chk({tag_of(m_src), "/R8/R9/R10 wake"}, {7'd0, wake_o}, {7'd0, m_wake});
    chk("R2 readback", cfg_rdata_o, {1'b0, m_lvl[0], 1'b0, m_src[2:0], 2'b00});
  end

  task automatic step(int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic wr(logic [7:0] d);
    cfg_we_i = 1; cfg_wdata_i = d;
    step(1);
    cfg_we_i = 0;
  endtask

  task automatic pins(logic [7:0] a, logic [7:0] b, logic [7:0] c);
    port0_i = a; port2_i = b; port3_i = c;
  endtask

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(3);
    #1 chk("R1 reset rdata", cfg_rdata_o, 8'h00);
    chk("R1 reset wake", {7'd0, wake_o}, 8'h00);
    rst_ni = 1;
    step(1);
    wr(8'hFF); #1 chk("R2 reserved ones", cfg_rdata_o, 8'h5C);
    wr(8'hA3); #1 chk("R2 reserved ignored", cfg_rdata_o, 8'h00);

    // R3: source 0 never wakes
    stop_active_i = 1;
    pins(8'hFF, 8'hFF, 8'hFF); step(5);
    pins(8'h00, 8'h00, 8'h00); step(5);
    #1 chk("R3 src0", {7'd0, wake_o}, 8'h00);
    wr(8'h40); pins(8'hFF, 8'hFF, 8'hFF); step(5);
    #1 chk("R3 src0 lvl1", {7'd0, wake_o}, 8'h00);

    // every source, both levels, with exact latency
    for (int s = 1; s < 8; s++) begin
      for (int l = 0; l < 2; l++) begin
        stop_active_i = 0;
        pins(l ? 8'hFF : 8'h00, l ? 8'hFF : 8'h00, l ? 8'hFF : 8'h00);
        wr({1'b0, l[0], 1'b0, s[2:0], 2'b00});
        step(4);
        stop_active_i = 1;
        step(4);
        #1 chk({tag_of(s), " R8 idle pins"}, {7'd0, wake_o}, 8'h00);
        pins(l ? 8'h00 : 8'hFF, l ? 8'h00 : 8'hFF, l ? 8'h00 : 8'hFF);
        step(2);
        #1 chk("R10 not yet", {7'd0, wake_o}, 8'h00);
        step(1);
        #1 chk({tag_of(s), " R8 R10 wake"}, {7'd0, wake_o}, 8'h01);
        pins(l ? 8'hFF : 8'h00, l ? 8'hFF : 8'h00, l ? 8'hFF : 8'h00);
        step(5);
        #1 chk("R9 held", {7'd0, wake_o}, 8'h01);
        stop_active_i = 0;
        step(1);
        #1 chk("R9 cleared", {7'd0, wake_o}, 8'h00);
      end
    end

    // single-pin selectivity and random sweep
    stop_active_i = 1;
    for (int s = 1; s < 8; s++) begin
      wr({3'b000, s[2:0], 2'b00});
      for (int b = 0; b < 24; b++) begin
        logic [23:0] v;
        stop_active_i = 0;
        pins(8'h00, 8'h00, 8'h00); step(3);
        stop_active_i = 1;
        v = 24'hFFFFFF; v[b] = 1'b0;
        pins(v[7:0], v[15:8], v[23:16]);
        step(4);
      end
    end
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 15) == 0) wr(8'($urandom));
      if ($urandom_range(0, 7) == 0) stop_active_i = ~stop_active_i;
      pins($urandom_range(0, 3) == 0 ? 8'($urandom) : 8'hFF,
           $urandom_range(0, 3) == 0 ? 8'($urandom) : 8'hFF,
           $urandom_range(0, 3) == 0 ? 8'($urandom) : 8'hFF);
      step(1);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule